// File: doc/BRIEF.md
# Store-Colored Load/Store Ordering Buffer

This block keeps the memory operations of an out-of-order core in order. Loads and stores are entered in program order into two separate circular queues. At entry, each load records a color: the store-queue position that the next store would take. The load's older stores are therefore exactly the live stores between the store head and that color. Store addresses and store data arrive independently, in any order, by store index. When a load's address arrives, the block searches only its colored range of older stores. It then does one of three things. It forwards data from the youngest older store at the same address whose data is present. It tells the core to retry the load later. Or it sends the load to the cache.

Loads remain in the load queue after they complete, until they retire. A snoop-invalidate address that hits a completed load marks it. The block raises a flush request naming the oldest marked load. Stores leave only at retirement, oldest first, and present their address and data as a commit to the cache. Both queue depths are parameters (power of two, 8 by default). A full queue withholds allocation readiness.

Top module: `ldst_order_buf`

## Requirements
- R1: After reset both queues are empty: alloc_ready is 1 for either kind, alloc_st_id and alloc_ld_id are 0, and fwd_valid, miss_valid, block_valid, flush_req and commit_valid are 0.
- R2: Allocation hands out store indices and load indices in increasing circular order. A load's color is the store allocation count at its entry. When the queue selected by alloc_is_store holds its full depth, alloc_ready is 0, and an alloc_valid in that state changes no index.
- R3: A load address sampled at rising edge E gives exactly one of fwd_valid, miss_valid or block_valid in the cycle after edge E+1, carrying the load's id. When no store in the load's color range has a matching address and none has an unknown address, the result is miss_valid with miss_addr equal to the load address.
- R4: When the youngest store in the color range with a matching address has its data, the result is fwd_valid with that store's data, even when the range wraps around the store queue.
- R5: When the youngest matching store in the color range has no data yet, the result is block_valid.
- R6: When any store in the color range has an unknown address, the result is block_valid.
- R7: Stores allocated after the load are ignored by the search: a younger store at the same address never supplies fwd_data.
- R8: A missed load completes only on ld_done_valid with its id. A forwarded load completes at once. A load retires from the queue head only after completing.
- R9: A snoop address matching a completed, unretired load sets flush_req the next cycle, with flush_id equal to the oldest such load. A snoop matching a load still awaiting the cache has no effect.
- R10: retire_st pops the oldest store and, in that cycle, drives commit_valid=1 with that store's address and data. The freed slot makes the store queue ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_valid | input | 1 | Allocate one entry this cycle |
| alloc_is_store | input | 1 | 1 allocates a store, 0 a load |
| alloc_ready | output | 1 | Selected queue has a free entry |
| alloc_st_id | output | 3 | Index the next store receives |
| alloc_ld_id | output | 3 | Index the next load receives |
| sta_valid | input | 1 | Store address arrives |
| sta_id | input | 3 | Store index for the address |
| sta_addr | input | 16 | Store address |
| std_valid | input | 1 | Store data arrives |
| std_id | input | 3 | Store index for the data |
| std_data | input | 32 | Store data |
| lda_valid | input | 1 | Load address arrives |
| lda_id | input | 3 | Load index |
| lda_addr | input | 16 | Load address |
| fwd_valid | output | 1 | Load satisfied by store forwarding |
| fwd_id | output | 3 | Forwarded load index |
| fwd_data | output | 32 | Forwarded data |
| miss_valid | output | 1 | Load goes to the cache |
| miss_id | output | 3 | Load index of the cache request |
| miss_addr | output | 16 | Cache request address |
| block_valid | output | 1 | Load must be retried |
| block_id | output | 3 | Blocked load index |
| ld_done_valid | input | 1 | Cache completed a load |
| ld_done_id | input | 3 | Completed load index |
| snoop_valid | input | 1 | Invalidation snoop |
| snoop_addr | input | 16 | Snooped address |
| flush_req | output | 1 | Some completed load was invalidated |
| flush_id | output | 3 | Oldest invalidated load |
| retire_ld | input | 1 | Retire the oldest load |
| retire_st | input | 1 | Retire the oldest store |
| commit_valid | output | 1 | Store commit to the cache this cycle |
| commit_addr | output | 16 | Committed store address |
| commit_data | output | 32 | Committed store data |

## Verification
The search is tried with three stores at one address bracketing a load's color. A forward of the middle store shows that both the youngest-match choice and the color bound work. The same younger load is then run three times: against a store with no address, against a store with an address but no data, and against a complete store. The block, block, forward sequence separates the two stall causes from forwarding. A load at a fresh address after a full wrap of the store queue, with two matching stores on either side of the wrap point, checks the circular age order. Snoops are applied first to a load still at the cache and then to two completed loads, which separates the completion condition from the oldest-first choice.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_PEND = 2'd1,
    LD_DONE = 2'd2
  } ld_state_e;
endpackage

// File: rtl/ldst_store_q.sv
module ldst_store_q #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  output logic          full,
  output logic [CW-1:0] tail,
  input  logic          sta_valid,
  input  logic [IW-1:0] sta_id,
  input  logic [AW-1:0] sta_addr,
  input  logic          std_valid,
  input  logic [IW-1:0] std_id,
  input  logic [DW-1:0] std_data,
  input  logic          retire,
  output logic          commit_valid,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data,
  input  logic [CW-1:0] srch_color,
  input  logic [AW-1:0] srch_addr,
  output logic          srch_wait,
  output logic          srch_hit,
  output logic          srch_rdy,
  output logic [DW-1:0] srch_data
);
  logic [CW-1:0]    head_q, head_d, tail_q, tail_d, count, in_range;
  logic [DEPTH-1:0] aok_q, aok_d, dok_q, dok_d;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [IW-1:0]    idx;

  assign count = tail_q - head_q;
  assign full  = (count == CW'(DEPTH));
  assign tail  = tail_q;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    aok_d  = aok_q;
    dok_d  = dok_q;
    if (alloc) begin
      aok_d[tail_q[IW-1:0]] = 1'b0;
      dok_d[tail_q[IW-1:0]] = 1'b0;
      tail_d = tail_q + CW'(1);
    end
    if (sta_valid) aok_d[sta_id] = 1'b1;
    if (std_valid) dok_d[std_id] = 1'b1;
    if (retire)    head_d = head_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      aok_q  <= '0;
      dok_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      aok_q  <= aok_d;
      dok_q  <= dok_d;
    end
  end

  always_ff @(posedge clk) begin
    if (sta_valid) addr_q[sta_id] <= sta_addr;
    if (std_valid) data_q[std_id] <= std_data;
  end

  // Range scan from oldest to youngest; later hits overwrite earlier ones.
  assign in_range = srch_color - head_q;
  always_comb begin
    srch_wait = 1'b0;
    srch_hit  = 1'b0;
    srch_rdy  = 1'b0;
    srch_data = '0;
    idx       = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_q[IW-1:0] + IW'(k);
      if (CW'(k) < in_range) begin
        if (!aok_q[idx]) begin
          srch_wait = 1'b1;
        end else if (addr_q[idx] == srch_addr) begin
          srch_hit  = 1'b1;
          srch_rdy  = dok_q[idx];
          srch_data = data_q[idx];
        end
      end
    end
  end

  assign commit_valid = retire && (count != '0);
  assign commit_addr  = addr_q[head_q[IW-1:0]];
  assign commit_data  = data_q[head_q[IW-1:0]];

  // R2
  sq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);
  // R10
  sq_retire_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (tail_q != head_q));
endmodule

// File: rtl/ldst_load_q.sv
module ldst_load_q
  import ldst_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int CW    = 4,
  localparam int IW   = $clog2(DEPTH),
  localparam int LCW  = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic [CW-1:0] alloc_color,
  output logic          full,
  output logic [IW-1:0] tail_idx,
  input  logic          lda_valid,
  input  logic [IW-1:0] lda_id,
  input  logic [AW-1:0] lda_addr,
  output logic [CW-1:0] rd_color,
  input  logic          res_fwd,
  input  logic          res_miss,
  input  logic [IW-1:0] res_id,
  input  logic          done_valid,
  input  logic [IW-1:0] done_id,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  input  logic          retire,
  output logic          flush_req,
  output logic [IW-1:0] flush_id
);
  logic [LCW-1:0]   head_q, head_d, tail_q, tail_d;
  ld_state_e        st_q [DEPTH];
  ld_state_e        st_d [DEPTH];
  logic [DEPTH-1:0] flag_q, flag_d;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [CW-1:0]    color_q [DEPTH];
  logic [IW-1:0]    idx;

  assign full     = ((tail_q - head_q) == LCW'(DEPTH));
  assign tail_idx = tail_q[IW-1:0];
  assign rd_color = color_q[lda_id];

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    st_d   = st_q;
    flag_d = flag_q;
    // Snoop sees completion state from before this cycle's updates.
    if (snoop_valid) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (st_q[i] == LD_DONE && addr_q[i] == snoop_addr) flag_d[i] = 1'b1;
      end
    end
    if (res_fwd)    st_d[res_id]  = LD_DONE;
    if (res_miss)   st_d[res_id]  = LD_PEND;
    if (done_valid) st_d[done_id] = LD_DONE;
    if (retire) begin
      st_d[head_q[IW-1:0]]   = LD_IDLE;
      flag_d[head_q[IW-1:0]] = 1'b0;
      head_d = head_q + LCW'(1);
    end
    if (alloc) begin
      st_d[tail_q[IW-1:0]]   = LD_IDLE;
      flag_d[tail_q[IW-1:0]] = 1'b0;
      tail_d = tail_q + LCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      flag_q <= '0;
      for (int i = 0; i < DEPTH; i++) st_q[i] <= LD_IDLE;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      flag_q <= flag_d;
      st_q   <= st_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc)     color_q[tail_q[IW-1:0]] <= alloc_color;
    if (lda_valid) addr_q[lda_id]          <= lda_addr;
  end

  // Oldest flagged load: scan youngest to oldest so the oldest wins.
  always_comb begin
    flush_req = 1'b0;
    flush_id  = '0;
    idx       = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      idx = head_q[IW-1:0] + IW'(k);
      if (flag_q[idx]) begin
        flush_req = 1'b1;
        flush_id  = idx;
      end
    end
  end

  // R8
  ld_done_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (st_q[done_id] == LD_PEND));
  // R8
  ld_retire_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> (st_q[head_q[IW-1:0]] == LD_DONE));
  // R2
  lq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !full);
endmodule

// File: rtl/ldst_order_buf.sv
module ldst_order_buf #(
  parameter int SQ_DEPTH = 8,
  parameter int LQ_DEPTH = 8,
  parameter int AW       = 16,
  parameter int DW       = 32,
  localparam int SIW     = $clog2(SQ_DEPTH),
  localparam int CW      = SIW + 1,
  localparam int LIW     = $clog2(LQ_DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_valid,
  input  logic           alloc_is_store,
  output logic           alloc_ready,
  output logic [SIW-1:0] alloc_st_id,
  output logic [LIW-1:0] alloc_ld_id,
  input  logic           sta_valid,
  input  logic [SIW-1:0] sta_id,
  input  logic [AW-1:0]  sta_addr,
  input  logic           std_valid,
  input  logic [SIW-1:0] std_id,
  input  logic [DW-1:0]  std_data,
  input  logic           lda_valid,
  input  logic [LIW-1:0] lda_id,
  input  logic [AW-1:0]  lda_addr,
  output logic           fwd_valid,
  output logic [LIW-1:0] fwd_id,
  output logic [DW-1:0]  fwd_data,
  output logic           miss_valid,
  output logic [LIW-1:0] miss_id,
  output logic [AW-1:0]  miss_addr,
  output logic           block_valid,
  output logic [LIW-1:0] block_id,
  input  logic           ld_done_valid,
  input  logic [LIW-1:0] ld_done_id,
  input  logic           snoop_valid,
  input  logic [AW-1:0]  snoop_addr,
  output logic           flush_req,
  output logic [LIW-1:0] flush_id,
  input  logic           retire_ld,
  input  logic           retire_st,
  output logic           commit_valid,
  output logic [AW-1:0]  commit_addr,
  output logic [DW-1:0]  commit_data
);
  logic [1:0]     rst_sync_q;
  logic           rst_i_n;
  logic           sq_full, lq_full, st_alloc, ld_alloc;
  logic [CW-1:0]  sq_tail, ld_color;
  logic           s1_valid;
  logic [LIW-1:0] s1_id;
  logic [AW-1:0]  s1_addr;
  logic [CW-1:0]  s1_color;
  logic           srch_wait, srch_hit, srch_rdy;
  logic [DW-1:0]  srch_data;
  logic           nx_fwd, nx_miss, nx_blk;
  logic           r_fwd, r_miss, r_blk;
  logic [LIW-1:0] r_id;
  logic [AW-1:0]  r_addr;
  logic [DW-1:0]  r_data;

  // Reset asserts at once, leaves on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign alloc_ready = alloc_is_store ? !sq_full : !lq_full;
  assign st_alloc    = alloc_valid &&  alloc_is_store && !sq_full;
  assign ld_alloc    = alloc_valid && !alloc_is_store && !lq_full;
  assign alloc_st_id = sq_tail[SIW-1:0];

  ldst_store_q #(.DEPTH(SQ_DEPTH), .AW(AW), .DW(DW)) i_sq (
    .clk(clk), .rst_n(rst_i_n),
    .alloc(st_alloc), .full(sq_full), .tail(sq_tail),
    .sta_valid(sta_valid), .sta_id(sta_id), .sta_addr(sta_addr),
    .std_valid(std_valid), .std_id(std_id), .std_data(std_data),
    .retire(retire_st), .commit_valid(commit_valid),
    .commit_addr(commit_addr), .commit_data(commit_data),
    .srch_color(s1_color), .srch_addr(s1_addr),
    .srch_wait(srch_wait), .srch_hit(srch_hit), .srch_rdy(srch_rdy),
    .srch_data(srch_data)
  );

  ldst_load_q #(.DEPTH(LQ_DEPTH), .AW(AW), .CW(CW)) i_lq (
    .clk(clk), .rst_n(rst_i_n),
    .alloc(ld_alloc), .alloc_color(sq_tail), .full(lq_full),
    .tail_idx(alloc_ld_id),
    .lda_valid(lda_valid), .lda_id(lda_id), .lda_addr(lda_addr),
    .rd_color(ld_color),
    .res_fwd(r_fwd), .res_miss(r_miss), .res_id(r_id),
    .done_valid(ld_done_valid), .done_id(ld_done_id),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .retire(retire_ld), .flush_req(flush_req), .flush_id(flush_id)
  );

  // Stage 2 decision from the stage 1 search.
  always_comb begin
    nx_blk  = s1_valid && (srch_wait || (srch_hit && !srch_rdy));
    nx_fwd  = s1_valid && !srch_wait && srch_hit && srch_rdy;
    nx_miss = s1_valid && !srch_wait && !srch_hit;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      s1_valid <= 1'b0;
      r_fwd    <= 1'b0;
      r_miss   <= 1'b0;
      r_blk    <= 1'b0;
    end else begin
      s1_valid <= lda_valid;
      r_fwd    <= nx_fwd;
      r_miss   <= nx_miss;
      r_blk    <= nx_blk;
    end
  end

  always_ff @(posedge clk) begin
    if (lda_valid) begin
      s1_id    <= lda_id;
      s1_addr  <= lda_addr;
      s1_color <= ld_color;
    end
    if (s1_valid) begin
      r_id   <= s1_id;
      r_addr <= s1_addr;
      r_data <= srch_data;
    end
  end

  assign fwd_valid   = r_fwd;
  assign fwd_id      = r_id;
  assign fwd_data    = r_data;
  assign miss_valid  = r_miss;
  assign miss_id     = r_id;
  assign miss_addr   = r_addr;
  assign block_valid = r_blk;
  assign block_id    = r_id;

  // R3
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({fwd_valid, miss_valid, block_valid}));
  // R3
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (fwd_valid || miss_valid || block_valid) |-> $past(lda_valid, 2));
endmodule

// File: tb/test_ldst_order_buf.sv
module test_ldst_order_buf;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid, alloc_is_store, alloc_ready;
  logic [2:0]  alloc_st_id, alloc_ld_id;
  logic        sta_valid, std_valid, lda_valid;
  logic [2:0]  sta_id, std_id, lda_id;
  logic [15:0] sta_addr, lda_addr, miss_addr, snoop_addr, commit_addr;
  logic [31:0] std_data, fwd_data, commit_data;
  logic        fwd_valid, miss_valid, block_valid, flush_req, commit_valid;
  logic [2:0]  fwd_id, miss_id, block_id, flush_id, ld_done_id;
  logic        ld_done_valid, snoop_valid, retire_ld, retire_st;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ldst_order_buf i_ldst_order_buf (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic is_st, input logic [2:0] exp_id, input string req);
    @(negedge clk);
    alloc_is_store = is_st;
    alloc_valid = 1'b1;
    #1;
    if (is_st) chk(alloc_st_id == exp_id, req, alloc_st_id, exp_id);
    else       chk(alloc_ld_id == exp_id, req, alloc_ld_id, exp_id);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic do_sta(input logic [2:0] id, input logic [15:0] a);
    @(negedge clk);
    sta_valid = 1'b1; sta_id = id; sta_addr = a;
    @(negedge clk);
    sta_valid = 1'b0;
  endtask

  task automatic do_std(input logic [2:0] id, input logic [31:0] d);
    @(negedge clk);
    std_valid = 1'b1; std_id = id; std_data = d;
    @(negedge clk);
    std_valid = 1'b0;
  endtask

  // kind: 0 forward, 1 miss, 2 block
  task automatic do_load(input logic [2:0] id, input logic [15:0] a, input int kind,
                         input logic [31:0] exp_d, input string req);
    @(negedge clk);
    lda_valid = 1'b1; lda_id = id; lda_addr = a;
    @(negedge clk);
    lda_valid = 1'b0;
    @(negedge clk);
    chk(fwd_valid == (kind == 0), req, fwd_valid, kind == 0);
    chk(miss_valid == (kind == 1), req, miss_valid, kind == 1);
    chk(block_valid == (kind == 2), req, block_valid, kind == 2);
    if (kind == 0) begin
      chk(fwd_id == id, req, fwd_id, id);
      chk(fwd_data == exp_d, req, fwd_data, exp_d);
    end else if (kind == 1) begin
      chk(miss_id == id, req, miss_id, id);
      chk(miss_addr == a, req, miss_addr, a);
    end else begin
      chk(block_id == id, req, block_id, id);
    end
  endtask

  task automatic do_done(input logic [2:0] id);
    @(negedge clk);
    ld_done_valid = 1'b1; ld_done_id = id;
    @(negedge clk);
    ld_done_valid = 1'b0;
  endtask

  task automatic do_snoop(input logic [15:0] a, input logic exp_req,
                          input logic [2:0] exp_id, input string req);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 1'b0;
    chk(flush_req == exp_req, req, flush_req, exp_req);
    if (exp_req) chk(flush_id == exp_id, req, flush_id, exp_id);
  endtask

  task automatic do_retire_st(input logic [15:0] ea, input logic [31:0] ed,
                              input bit check_payload);
    @(negedge clk);
    retire_st = 1'b1;
    #1;
    chk(commit_valid == 1'b1, "R10 commit_valid", commit_valid, 1);
    if (check_payload) begin
      chk(commit_addr == ea, "R10 commit_addr", commit_addr, ea);
      chk(commit_data == ed, "R10 commit_data", commit_data, ed);
    end
    @(negedge clk);
    retire_st = 1'b0;
  endtask

  task automatic do_retire_ld();
    @(negedge clk);
    retire_ld = 1'b1;
    @(negedge clk);
    retire_ld = 1'b0;
  endtask

  task automatic t_reset();
    alloc_is_store = 1'b1;
    #1;
    chk(alloc_ready == 1'b1, "R1 store ready", alloc_ready, 1);
    alloc_is_store = 1'b0;
    #1;
    chk(alloc_ready == 1'b1, "R1 load ready", alloc_ready, 1);
    chk(alloc_st_id == 3'd0 && alloc_ld_id == 3'd0, "R1 ids", {alloc_st_id, alloc_ld_id}, 0);
    chk({fwd_valid, miss_valid, block_valid, flush_req, commit_valid} == 5'b0,
        "R1 outputs idle", {fwd_valid, miss_valid, block_valid, flush_req, commit_valid}, 0);
  endtask

  task automatic t_plain_miss();
    do_alloc(1'b0, 3'd0, "R2 load id 0");
    do_load(3'd0, 16'h0100, 1, 0, "R3 no stores gives miss");
    do_done(3'd0);
    do_retire_ld();
    chk(alloc_ld_id == 3'd1, "R8 retire after done", alloc_ld_id, 1);
  endtask

  task automatic t_forward_youngest();
    do_alloc(1'b1, 3'd0, "R2 store id 0");
    do_alloc(1'b1, 3'd1, "R2 store id 1");
    do_alloc(1'b0, 3'd1, "R2 load id 1");
    do_alloc(1'b1, 3'd2, "R2 store id 2");
    do_sta(3'd0, 16'h0200); do_std(3'd0, 32'h11);
    do_sta(3'd1, 16'h0200); do_std(3'd1, 32'h22);
    do_sta(3'd2, 16'h0200); do_std(3'd2, 32'h33);
    do_load(3'd1, 16'h0200, 0, 32'h22, "R4 R7 youngest older store forwards");
  endtask

  task automatic t_stalls();
    do_alloc(1'b1, 3'd3, "R2 store id 3");
    do_alloc(1'b0, 3'd2, "R2 load id 2");
    do_load(3'd2, 16'h0300, 2, 0, "R6 unknown store address blocks");
    do_sta(3'd3, 16'h0300);
    do_load(3'd2, 16'h0300, 2, 0, "R5 store data missing blocks");
    do_std(3'd3, 32'h44);
    do_load(3'd2, 16'h0300, 0, 32'h44, "R4 forward after data");
  endtask

  task automatic t_snoop();
    do_alloc(1'b0, 3'd3, "R2 load id 3");
    do_load(3'd3, 16'h0400, 1, 0, "R3 no address match gives miss");
    do_snoop(16'h0400, 1'b0, 3'd0, "R9 pending load ignores snoop");
    do_done(3'd3);
    do_snoop(16'h0300, 1'b1, 3'd2, "R9 snoop flags completed load");
    do_snoop(16'h0200, 1'b1, 3'd1, "R9 oldest flagged load reported");
  endtask

  task automatic t_retire();
    do_retire_st(16'h0200, 32'h11, 1'b1);
    do_retire_st(16'h0200, 32'h22, 1'b1);
    do_retire_st(16'h0200, 32'h33, 1'b1);
    do_retire_st(16'h0300, 32'h44, 1'b1);
    do_retire_ld(); do_retire_ld(); do_retire_ld();
    #1;
    chk(flush_req == 1'b0, "R9 flags leave with retired loads", flush_req, 0);
  endtask

  task automatic t_full_wrap();
    for (int i = 0; i < 8; i++) do_alloc(1'b1, 3'(4 + i), "R2 store ids wrap");
    @(negedge clk);
    alloc_is_store = 1'b1;
    #1;
    chk(alloc_ready == 1'b0, "R2 full store queue not ready", alloc_ready, 0);
    alloc_valid = 1'b1;
    @(negedge clk);
    alloc_valid = 1'b0;
    #1;
    chk(alloc_st_id == 3'd4, "R2 stalled alloc ignored", alloc_st_id, 4);
    do_retire_st(0, 0, 1'b0);
    alloc_is_store = 1'b1;
    #1;
    chk(alloc_ready == 1'b1, "R10 slot freed", alloc_ready, 1);
    do_alloc(1'b1, 3'd4, "R2 store reuses slot 4");
    for (int i = 0; i < 8; i++) begin
      if (i == 4)      do_sta(3'(i), 16'h0500);
      else if (i == 5) do_sta(3'(i), 16'h0500);
      else             do_sta(3'(i), 16'(16'h0600 + i));
    end
    do_std(3'd5, 32'h66);
    do_std(3'd4, 32'h55);
    do_alloc(1'b0, 3'd4, "R2 load id 4");
    do_load(3'd4, 16'h0500, 0, 32'h55, "R4 youngest across wrap");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 1'b0; alloc_is_store = 1'b0;
    sta_valid = 1'b0; sta_id = '0; sta_addr = '0;
    std_valid = 1'b0; std_id = '0; std_data = '0;
    lda_valid = 1'b0; lda_id = '0; lda_addr = '0;
    ld_done_valid = 1'b0; ld_done_id = '0;
    snoop_valid = 1'b0; snoop_addr = '0;
    retire_ld = 1'b0; retire_st = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_plain_miss();
    t_forward_youngest();
    t_stalls();
    t_snoop();
    t_retire();
    t_full_wrap();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule